// File: doc/BRIEF.md
# Vector Element Saturation Unit

This block takes one integer element result that an arithmetic stage has already produced at a wide internal width. It fits that result into a destination element of 8, 16, 32 or 64 bits. With saturation enabled, a result outside the destination range is clamped to the nearest limit, in either the unsigned or the signed sense. With saturation disabled, the result is simply truncated. The block handles one element per clock and registers its outputs once.

In record mode the block also builds a four-bit condition field for the element. Its less-than, greater-than and equal bits describe the stored value. Its overflow bit reports only whether this element was clamped; no summary overflow state from earlier operations is read or merged into it. Carry outputs from the arithmetic stage pass through unchanged unless saturation is requested, in which case they are forced to zero. A request for saturation together with overflow detection is flagged as an illegal instruction.

Top module: `vec_elem_sat`

## Requirements
- R1: With saturation enabled and signed select clear, the raw result (a two's complement value of RAW_W bits) is clamped to 0 when it is negative, to 2^W-1 when it exceeds that value, and otherwise passed through, W being the selected destination width.
- R2: With saturation enabled and signed select set, the raw result is clamped to the range -2^(W-1) to 2^(W-1)-1. The W-bit two's complement pattern is output.
- R3: In record mode with saturation enabled, condition bit 0 (overflow) is 1 exactly when the element was clamped.
- R4: With saturation disabled, the output is the low W bits of the raw result, and the overflow bit is 0.
- R5: The width selector encodes 0=8, 1=16, 2=32, 3=64 bits. Output bits above W are always 0.
- R6: In record mode, condition bits 3, 2 and 1 are less-than, greater-than and equal-to-zero of the output element. The element is read as W-bit signed when signed select is set and as unsigned otherwise, so exactly one of these three bits is set.
- R7: With record mode clear, the condition field is all zero.
- R8: The illegal flag is 1 exactly when saturation and overflow-enable are both requested.
- R9: Carry outputs are 0 when saturation is enabled, and otherwise equal the carry inputs.
- R10: All outputs appear one clock after the input with in_valid high. A cycle with in_valid low yields out_valid low and all outputs zero. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element present this cycle |
| raw_result | input | RAW_W | Wide two's complement result |
| width_sel | input | SELW | Destination width code |
| signed_sel | input | 1 | Signed clamping and comparison |
| sat_en | input | 1 | Saturation requested |
| rec_en | input | 1 | Record mode: produce condition field |
| oe_en | input | 1 | Overflow-enable requested |
| carry_in | input | 2 | Carry bits from the operation |
| out_valid | output | 1 | Registered element valid |
| elem_out | output | ELEM_MAX | Clamped or truncated element, zero-extended |
| cond_out | output | 4 | {lt, gt, eq, ov} |
| illegal_out | output | 1 | Illegal combination flag |
| carry_out | output | 2 | Carry bits, zeroed under saturation |

## Verification
Every result of an element (value, condition field, illegal flag, carry and valid) comes out of a single register stage. Each is therefore due exactly one clock after the element is presented. The bench drives each element on a falling edge and compares every output on the next falling edge, half a period after the registering edge. In that same step it drives the next element, so a mismatch always points at the element presented just before. Idle cycles are checked the same way, one edge later, for a zeroed output.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic ov;
    } cond_t;

    localparam int unsigned MIN_ELEM_W = 8;

endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int unsigned RAW_W    = 80,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned ELEM_MAX = 64
) (
    input  logic signed [RAW_W-1:0] raw,
    input  logic                    signed_sel,
    input  logic                    sat_en,
    output logic [ELEM_MAX-1:0]     val,
    output logic                    clip
);

    localparam logic signed [RAW_W-1:0] UMAX = {{(RAW_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    localparam logic signed [RAW_W-1:0] SMAX = {{(RAW_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [RAW_W-1:0] SMIN = ~SMAX;

    logic              above;
    logic              below;
    logic [LANE_W-1:0] narrow;

    always_comb begin
        if (signed_sel) begin
            above = raw > SMAX;
            below = raw < SMIN;
        end else begin
            above = raw > UMAX;
            below = raw[RAW_W-1];
        end
        clip = sat_en & (above | below);

        narrow = raw[LANE_W-1:0];
        if (sat_en && above) begin
            narrow = signed_sel ? {1'b0, {(LANE_W-1){1'b1}}} : {LANE_W{1'b1}};
        end else if (sat_en && below) begin
            narrow = signed_sel ? {1'b1, {(LANE_W-1){1'b0}}} : {LANE_W{1'b0}};
        end

        val = '0;
        val[LANE_W-1:0] = narrow;
    end

endmodule

// File: rtl/sat_flags.sv
module sat_flags #(
    parameter int unsigned ELEM_MAX = 64,
    parameter int unsigned NW       = 4,
    parameter int unsigned SELW     = 2
) (
    input  logic [ELEM_MAX-1:0] val,
    input  logic [SELW-1:0]     width_sel,
    input  logic                signed_sel,
    output logic                lt,
    output logic                gt,
    output logic                eq
);

    logic [NW-1:0] top_bits;

    for (genvar g = 0; g < NW; g++) begin : g_msb
        assign top_bits[g] = val[(sat_pkg::MIN_ELEM_W << g) - 1];
    end

    always_comb begin
        eq = (val == '0);
        lt = signed_sel & top_bits[width_sel];
        gt = ~eq & ~lt;
    end

endmodule

// File: rtl/vec_elem_sat.sv
module vec_elem_sat #(
    parameter int unsigned ELEM_MAX = 64,
    parameter int unsigned RAW_W    = 80,
    parameter int unsigned NW       = $clog2(ELEM_MAX / sat_pkg::MIN_ELEM_W) + 1,
    parameter int unsigned SELW     = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [RAW_W-1:0] raw_result,
    input  logic [SELW-1:0]         width_sel,
    input  logic                    signed_sel,
    input  logic                    sat_en,
    input  logic                    rec_en,
    input  logic                    oe_en,
    input  logic [1:0]              carry_in,
    output logic                    out_valid,
    output logic [ELEM_MAX-1:0]     elem_out,
    output logic [3:0]              cond_out,
    output logic                    illegal_out,
    output logic [1:0]              carry_out
);

    typedef struct packed {
        logic                valid;
        logic [ELEM_MAX-1:0] elem;
        sat_pkg::cond_t      cond;
        logic                illegal;
        logic [1:0]          carry;
    } stage_t;

    logic [ELEM_MAX-1:0] lane_val [NW];
    logic [NW-1:0]       lane_clip;
    logic [ELEM_MAX-1:0] pick_val;
    logic                pick_clip;
    logic                f_lt;
    logic                f_gt;
    logic                f_eq;
    stage_t              st_d;
    stage_t              st_q;

    for (genvar g = 0; g < NW; g++) begin : g_lane
        sat_lane #(
            .RAW_W   (RAW_W),
            .LANE_W  (sat_pkg::MIN_ELEM_W << g),
            .ELEM_MAX(ELEM_MAX)
        ) u_lane (
            .raw       (raw_result),
            .signed_sel(signed_sel),
            .sat_en    (sat_en),
            .val       (lane_val[g]),
            .clip      (lane_clip[g])
        );
    end

    assign pick_val  = lane_val[width_sel];
    assign pick_clip = lane_clip[width_sel];

    sat_flags #(
        .ELEM_MAX(ELEM_MAX),
        .NW      (NW),
        .SELW    (SELW)
    ) u_flags (
        .val       (pick_val),
        .width_sel (width_sel),
        .signed_sel(signed_sel),
        .lt        (f_lt),
        .gt        (f_gt),
        .eq        (f_eq)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.valid   = 1'b1;
            st_d.elem    = pick_val;
            st_d.illegal = sat_en & oe_en;
            st_d.carry   = sat_en ? 2'b00 : carry_in;
            if (rec_en) begin
                st_d.cond.lt = f_lt;
                st_d.cond.gt = f_gt;
                st_d.cond.eq = f_eq;
                st_d.cond.ov = pick_clip;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign elem_out    = st_q.elem;
    assign cond_out    = st_q.cond;
    assign illegal_out = st_q.illegal;
    assign carry_out   = st_q.carry;

endmodule

// File: rtl/vec_elem_sat_chk.sv
module vec_elem_sat_chk #(
    parameter int unsigned ELEM_MAX = 64,
    parameter int unsigned SELW     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SELW-1:0]     width_sel,
    input logic                signed_sel,
    input logic                sat_en,
    input logic                rec_en,
    input logic                oe_en,
    input logic                out_valid,
    input logic [ELEM_MAX-1:0] elem_out,
    input logic [3:0]          cond_out,
    input logic                illegal_out,
    input logic [1:0]          carry_out
);

    assert_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (illegal_out == $past(sat_en && oe_en)));

    assert_carry_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en) |=> (carry_out == 2'b00));

    assert_no_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rec_en) |=> (cond_out == 4'b0000));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_en) |=> !cond_out[0]);

    assert_one_relation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> ($countones(cond_out[3:1]) == 1));

    assert_unsigned_not_lt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en && !signed_sel) |=> !cond_out[3]);

    assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_sel == '0) |=> (elem_out[ELEM_MAX-1:8] == '0));

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && elem_out == '0 && !illegal_out));

endmodule

bind vec_elem_sat vec_elem_sat_chk #(
    .ELEM_MAX(ELEM_MAX),
    .SELW    (SELW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .width_sel  (width_sel),
    .signed_sel (signed_sel),
    .sat_en     (sat_en),
    .rec_en     (rec_en),
    .oe_en      (oe_en),
    .out_valid  (out_valid),
    .elem_out   (elem_out),
    .cond_out   (cond_out),
    .illegal_out(illegal_out),
    .carry_out  (carry_out)
);

// File: tb/vec_elem_sat_bench.sv
`timescale 1ns/1ps
module vec_elem_sat_bench;

    localparam int RAW_W = 80;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [RAW_W-1:0] raw_result = '0;
    logic [1:0]              width_sel = '0;
    logic                    signed_sel = 1'b0;
    logic                    sat_en = 1'b0;
    logic                    rec_en = 1'b0;
    logic                    oe_en = 1'b0;
    logic [1:0]              carry_in = '0;
    logic                    out_valid;
    logic [63:0]             elem_out;
    logic [3:0]              cond_out;
    logic                    illegal_out;
    logic [1:0]              carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    vec_elem_sat u_vec_elem_sat (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .raw_result (raw_result),
        .width_sel  (width_sel),
        .signed_sel (signed_sel),
        .sat_en     (sat_en),
        .rec_en     (rec_en),
        .oe_en      (oe_en),
        .carry_in   (carry_in),
        .out_valid  (out_valid),
        .elem_out   (elem_out),
        .cond_out   (cond_out),
        .illegal_out(illegal_out),
        .carry_out  (carry_out)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    function automatic logic [63:0] model_elem(logic signed [RAW_W-1:0] raw, int sel,
                                               bit sgn, bit sat, output bit clipped);
        int w = 8 << sel;
        logic signed [RAW_W-1:0] one = 1;
        logic signed [RAW_W-1:0] umax = (one <<< w) - 1;
        logic signed [RAW_W-1:0] smax = (one <<< (w - 1)) - 1;
        logic signed [RAW_W-1:0] smin = -(one <<< (w - 1));
        logic signed [RAW_W-1:0] v = raw;
        clipped = 1'b0;
        if (sat) begin
            if (sgn) begin
                if (raw > smax) begin v = smax; clipped = 1'b1; end
                else if (raw < smin) begin v = smin; clipped = 1'b1; end
            end else begin
                if (raw > umax) begin v = umax; clipped = 1'b1; end
                else if (raw < 0) begin v = 0; clipped = 1'b1; end
            end
        end
        v = v & umax;
        return v[63:0];
    endfunction

    // Drive one element, then check it on the following falling edge.
    task automatic run(logic signed [RAW_W-1:0] raw, int sel, bit sgn, bit sat,
                       bit rec, bit oe, logic [1:0] cin);
        bit          clipped;
        logic [63:0] e;
        logic [3:0]  c;
        int          w = 8 << sel;
        bit          neg;
        string       vreq;
        in_valid   = 1'b1;
        raw_result = raw;
        width_sel  = sel[1:0];
        signed_sel = sgn;
        sat_en     = sat;
        rec_en     = rec;
        oe_en      = oe;
        carry_in   = cin;
        e   = model_elem(raw, sel, sgn, sat, clipped);
        neg = sgn && e[w-1];
        c   = 4'b0000;
        if (rec) c = {neg, !neg && (e != 0), e == 0, clipped};
        vreq = !sat ? "R4 truncate" : (sgn ? "R2 signed clamp" : "R1 unsigned clamp");
        @(negedge clk);
        check(vreq, elem_out, e);
        check(rec ? "R3/R6 cond field" : "R7 cond cleared", {60'd0, cond_out}, {60'd0, c});
        check("R8 illegal", {63'd0, illegal_out}, {63'd0, sat && oe});
        check("R9 carry", {62'd0, carry_out}, {62'd0, sat ? 2'b00 : cin});
        check("R10 valid", {63'd0, out_valid}, 64'd1);
    endtask

    initial begin
        logic signed [RAW_W-1:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        check("R10 reset elem", elem_out, 64'd0);
        check("R10 reset cond", {60'd0, cond_out}, 64'd0);
        rst_n = 1'b1;

        // R1 corners at 8 bits
        run(80'sd300, 0, 0, 1, 1, 0, 2'b11);
        run(-80'sd5, 0, 0, 1, 1, 0, 2'b01);
        run(80'sd255, 0, 0, 1, 1, 0, 2'b10);
        run(80'sd0, 0, 0, 1, 1, 0, 2'b00);
        // R2 corners at 16 bits
        run(80'sd40000, 1, 1, 1, 1, 0, 2'b00);
        run(-80'sd40000, 1, 1, 1, 1, 0, 2'b00);
        run(-80'sd32768, 1, 1, 1, 1, 0, 2'b00);
        run(80'sd32767, 1, 1, 1, 1, 0, 2'b00);
        // R5 widest lane, unsigned and signed
        run(80'sd1 <<< 64, 3, 0, 1, 1, 0, 2'b00);
        run(-(80'sd1 <<< 70), 3, 1, 1, 1, 0, 2'b00);
        run(80'sd1 <<< 40, 2, 0, 1, 1, 0, 2'b00);
        // R4 wrap without saturation
        run(80'sh1ff, 0, 0, 0, 1, 0, 2'b11);
        run(-80'sd1, 2, 1, 0, 1, 0, 2'b10);
        // R7 record off, R8 illegal combination
        run(80'sd300, 0, 0, 1, 0, 1, 2'b11);
        run(80'sd7, 1, 1, 0, 1, 1, 2'b01);

        // R10 idle cycle
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 idle valid", {63'd0, out_valid}, 64'd0);
        check("R10 idle elem", elem_out, 64'd0);

        for (int i = 0; i < 3000; i++) begin
            r = $signed({$urandom, $urandom, $urandom});
            r = r >>> ($urandom % 79);
            run(r, $urandom % 4, $urandom % 2, ($urandom % 4) != 0,
                ($urandom % 4) != 0, ($urandom % 5) == 0, 2'($urandom));
        end

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule